// File: doc/BRIEF.md
# Read-to-acquire hardware spinlock bank

This block holds a set of hardware spinlocks shared by several processors over one memory-mapped register bus. Each lock is one word-sized register. A processor tries to take a lock by reading its register. The read itself is the test-and-set. A result of 1 means the lock was free and now belongs to the reader. A result of 0 means another agent already holds it. The holder gives the lock back by writing 0 to the same register.

The side effect happens only on a qualified read strobe, never on the address alone. The bus has one access per cycle, so the test and the set of a read cannot be split by another access. Read data is registered and returned one cycle after the strobe. Addresses that do not name a lock read as 0 and change nothing. The bus is a plain strobe interface: there is no valid/ready handshake, and every strobe is accepted in the cycle it is asserted.

Top module: `spl_bank`

## Requirements
- R1: After reset every lock is free, so the first read of any lock returns 1.
- R2: A read of a free lock returns 1 in bit 0 and leaves that lock taken.
- R3: A read of a taken lock returns 0 and leaves that lock taken.
- R4: Writing the value 0 to a lock register frees that lock.
- R5: Writing a nonzero value to a lock register has no effect; the lock keeps its state.
- R6: Lock n (0 to NUM_LOCKS-1, default 30 locks) sits at byte address 0x404 + 4*n. Reads or writes at any other address (below 0x404, at or beyond 0x404 + 4*NUM_LOCKS, or not word aligned) read as 0 and change no lock.
- R7: Read data appears on `bus_rdata` in the cycle after the read strobe. In a cycle after a cycle with no read strobe, `bus_rdata` is 0.
- R8: When `bus_rd` and `bus_wr` are asserted in the same cycle, the read is performed and the write is ignored.
- R9: Bits 31:1 of `bus_rdata` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_rd | input | 1 | Read strobe; acquires a lock on a hit |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; 0 releases the addressed lock |
| bus_rdata | output | 32 | Registered read result, bit 0 = acquired |

## Verification
A lock bit that is wrongly set or wrongly cleared shows up at the ports only on the next read of that lock. That read returns the opposite of the expected grant, one cycle after its strobe. The bench therefore keeps a model of every lock and reads each one repeatedly during random traffic and once more at the end. This bounds how long a corrupted lock can stay hidden. A decode fault that hits a wrong neighbour, or a side effect from a miss address, shows up as a grant mismatch on that neighbour's next read.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // Kind of access presented by the bus in one cycle
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } spl_acc_e;

  // Read wins over write when both strobes are seen together
  function automatic spl_acc_e spl_classify(input logic rd, input logic wr);
    if (rd)      return ACC_READ;
    else if (wr) return ACC_WRITE;
    else         return ACC_IDLE;
  endfunction
endpackage

// File: rtl/spl_addr_decode.sv
module spl_addr_decode #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 30,
  parameter int BASE_OFF  = 'h404
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_LOCKS-1:0] sel,
  output logic [NUM_LOCKS-1:0] take,
  output logic [NUM_LOCKS-1:0] release_req
);
  import spl_pkg::*;

  spl_acc_e acc;
  logic     wzero;

  assign acc   = spl_classify(rd, wr);
  assign wzero = (wdata == '0);

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(BASE_OFF + 4 * i);
    assign sel[i]         = (addr == LOCK_ADDR);
    assign take[i]        = sel[i] && (acc == ACC_READ);
    assign release_req[i] = sel[i] && (acc == ACC_WRITE) && wzero;
  end
endmodule

// File: rtl/spl_lock_cell.sv
module spl_lock_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic release_req,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held <= 1'b0;
    else if (take)        held <= 1'b1;
    else if (release_req) held <= 1'b0;
  end
endmodule

// File: rtl/spl_rdata_stage.sv
module spl_rdata_stage #(
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  logic [NUM_LOCKS-1:0] sel,
  input  logic [NUM_LOCKS-1:0] held,
  output logic [DATA_W-1:0]    rdata
);
  logic grant;

  // Grant reflects lock state before this cycle's update
  assign grant = rd && (|(sel & ~held));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= {{(DATA_W-1){1'b0}}, grant};
  end
endmodule

// File: rtl/spl_bank.sv
module spl_bank #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 30,
  parameter int BASE_OFF  = 'h404
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [NUM_LOCKS-1:0] lock_sel;
  logic [NUM_LOCKS-1:0] lock_take;
  logic [NUM_LOCKS-1:0] lock_rel;
  logic [NUM_LOCKS-1:0] lock_held;

  spl_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_LOCKS(NUM_LOCKS), .BASE_OFF(BASE_OFF)
  ) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .sel(lock_sel), .take(lock_take), .release_req(lock_rel)
  );

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    spl_lock_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .take(lock_take[i]), .release_req(lock_rel[i]),
      .held(lock_held[i])
    );
  end

  spl_rdata_stage #(.DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd),
    .sel(lock_sel), .held(lock_held), .rdata(bus_rdata)
  );
endmodule

// File: rtl/spl_bank_chk.sv
module spl_bank_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LOCKS-1:0] lock_held
);
  // A grant adds exactly one taken lock
  p_grant_adds_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[0] |-> $countones(lock_held) == $countones($past(lock_held)) + 1);

  // No lock becomes taken without a grant being returned
  p_take_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lock_held) > $countones($past(lock_held))) |-> bus_rdata[0]);

  // Locks are freed only by a lone zero write
  p_free_needs_zero_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lock_held) < $countones($past(lock_held)))
      |-> $past(bus_wr && !bus_rd && bus_wdata == '0));

  // No read strobe, no read data
  p_idle_rdata_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  // Combined strobes never free a lock
  p_rdwr_no_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> $countones(lock_held) >= $countones($past(lock_held)));

  // Upper data bits stay zero
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:1] == '0);
endmodule

bind spl_bank spl_bank_chk #(.DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_held(lock_held)
);

// File: tb/tb_spl_bank.sv
module tb_spl_bank;
  localparam int NL   = 30;
  localparam int BASE = 'h404;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit model_held [NL];

  spl_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  // Lock index from address per R6, -1 on a miss
  function automatic int lock_of(input logic [15:0] a);
    int off = int'(a) - BASE;
    if (off < 0 || (off % 4) != 0 || (off / 4) >= NL) return -1;
    return off / 4;
  endfunction

  function automatic logic [31:0] expect_read(input logic [15:0] a);
    int n = lock_of(a);
    if (n < 0) return 32'd0;
    return model_held[n] ? 32'd0 : 32'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_access(input logic rd, input logic wr, input logic [15:0] a,
                           input logic [31:0] d, input string req);
    logic [31:0] exp;
    int n;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    n = lock_of(a);
    exp = rd ? expect_read(a) : 32'd0;
    if (n >= 0) begin
      if (rd) model_held[n] = 1'b1;
      else if (wr && d == 32'd0) model_held[n] = 1'b0;
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic rd_lock(input int n, input string req);
    do_access(1'b1, 1'b0, 16'(BASE + 4 * n), 32'd0, req);
  endtask

  task automatic wr_lock(input int n, input logic [31:0] d, input string req);
    do_access(1'b0, 1'b1, 16'(BASE + 4 * n), d, req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < NL; i++) model_held[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", bus_rdata, 32'd0);
    rst_n = 1'b1;

    // Directed corner cases
    rd_lock(0, "R1 R2 first read of lock 0");
    rd_lock(0, "R3 second read of lock 0");
    wr_lock(0, 32'h5, "R5 R7 nonzero write");
    rd_lock(0, "R5 lock still taken");
    wr_lock(0, 32'h0, "R4 R7 zero write");
    rd_lock(0, "R4 lock freed then retaken");
    rd_lock(NL - 1, "R2 R6 last lock");
    do_access(1'b1, 1'b0, 16'h0400, 0, "R6 below base");
    do_access(1'b1, 1'b0, 16'(BASE + 4 * NL), 0, "R6 past end");
    do_access(1'b1, 1'b0, 16'h0409, 0, "R6 misaligned");
    do_access(1'b0, 1'b1, 16'h0405, 0, "R6 misaligned write");
    rd_lock(1, "R6 neighbour untouched by misaligned");
    do_access(1'b1, 1'b1, 16'(BASE + 4 * 2), 0, "R8 read+write free lock");
    do_access(1'b1, 1'b1, 16'(BASE + 4 * 2), 0, "R8 read+write taken lock");
    rd_lock(2, "R8 write ignored, still taken");

    // Random traffic
    for (int k = 0; k < 3000; k++) begin
      int sel = int'($urandom_range(0, 99));
      int n   = int'($urandom_range(0, NL - 1));
      if (sel < 55)      rd_lock(n, "R2 R3 R9 random read");
      else if (sel < 72) wr_lock(n, 32'd0, "R4 R7 random release");
      else if (sel < 82) wr_lock(n, $urandom() | 32'd1, "R5 random nonzero write");
      else if (sel < 92) do_access(1'b1, 1'b0, 16'($urandom_range(0, 16'hFFFF)), 0, "R6 random address read");
      else               do_access(1'b1, 1'b1, 16'(BASE + 4 * n), 32'd0, "R8 random read+write");
    end

    // Final sweep exposes any lock state hidden during traffic
    for (int i = 0; i < NL; i++) rd_lock(i, "R2 R3 final sweep");
    for (int i = 0; i < NL; i++) rd_lock(i, "R3 all taken after sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule